// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of 32 pins, run by software through a small memory-mapped register port that moves whole 32-bit words. It keeps an output latch that supplies the level each pad drives. It also keeps a direction register, and each bit of that register enables one pad's output driver. Three write-only aliases of the output latch change chosen bits in one bus write: one sets bits, one clears bits and one inverts bits. Software therefore does not need a read-modify-write sequence, and two agents that own different pins cannot overwrite each other's pins.

Pin levels come in through a two-stage synchronizer. Software reads them through a read-only input register. Pin multiplexing, pull and drive-strength control, interrupt detection and bridging to a system bus are handled by other blocks. The register port is a single-cycle request interface. A write takes effect at the clock edge that accepts it. Read data appears on `reg_rdata` one cycle after the read is accepted, and `reg_rdata` holds that value until the next read.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output latch, the direction register and `reg_rdata` become zero. As a result `pin_out` and `pin_oe` are all zero and every pin is an input.
- R2: A write to byte offset 0x00 loads the output latch with `reg_wdata`. A read of 0x00 returns the latch, and `pin_out` always equals the latch.
- R3: A write to offset 0x04 sets to 1 each latch bit whose `reg_wdata` bit is 1. All other latch bits keep their value.
- R4: A write to offset 0x08 clears to 0 each latch bit whose `reg_wdata` bit is 1. All other latch bits keep their value.
- R5: A write to offset 0x0C inverts each latch bit whose `reg_wdata` bit is 1. All other latch bits keep their value.
- R6: A write to offset 0x14 loads the direction register, and a read of 0x14 returns it. `pin_oe[i]` equals direction bit i, where 1 means output and 0 means input.
- R7: A read of offset 0x10 returns `pin_in` as sampled two clock edges before the edge that accepts the read. The path runs through two synchronizing flops.
- R8: Reads of 0x04, 0x08 and 0x0C return zero. Writes to 0x10 change nothing. Any address other than the six listed, including addresses that are not word-aligned, reads as zero and ignores writes.
- R9: `reg_rdata` updates only at the edge after a cycle with `reg_valid`=1 and `reg_write`=0. It holds its value in all other cycles, and writes leave the latch and the direction register unchanged except as R2 to R6 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_valid | input | 1 | Register access request in this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Level driven on each pad |
| pin_oe | output | 32 | Pad output enable, 1 = drive |

## Verification
The bench checks that the set, clear and invert aliases change only the bits selected by the write data. A design that wrote the word straight into the latch would wipe out the unselected pins, and the following readback of 0x00 would show it. The bench reads the aliases, the unmapped addresses and a misaligned address, and writes the input register. A decode that aliased or ignored offset bits would return latch contents or corrupt the latch. Continuous reads of the input register around a pin change check the two-cycle synchronizer delay; one flop too few or too many moves the new value to the wrong cycle. A reset applied in the middle of a run checks that output drive and direction both return to zero.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO port.
// Assumes byte addressing with 32-bit words; offsets are exact byte addresses.
package gpio_port_pkg;

    localparam int unsigned OFS_DATA = 32'h00;
    localparam int unsigned OFS_SET  = 32'h04;
    localparam int unsigned OFS_CLR  = 32'h08;
    localparam int unsigned OFS_TGL  = 32'h0C;
    localparam int unsigned OFS_IN   = 32'h10;
    localparam int unsigned OFS_DIR  = 32'h14;

    // One-hot-ish strobes produced by the register decoder.
    typedef struct packed {
        logic data_wr;
        logic set_wr;
        logic clr_wr;
        logic tgl_wr;
        logic dir_wr;
        logic rd_en;
        logic rd_data;
        logic rd_in;
        logic rd_dir;
    } gpio_sel_t;

endpackage

// File: rtl/gpio_reg_decode.sv
// Register address decoder.
// Turns one request (valid/write/addr) into write and read strobes.
// Assumes an exact byte-address match; misaligned or unmapped addresses hit nothing.
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_t         sel
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_TGL  = ADDR_W'(OFS_TGL);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

    logic wr_req;
    logic rd_req;

    // Split the request into its read and write halves.
    always_comb begin
        wr_req = valid && write;
        rd_req = valid && !write;
    end

    // Match the address against each register offset.
    always_comb begin
        sel         = '0;
        sel.data_wr = wr_req && (addr == A_DATA);
        sel.set_wr  = wr_req && (addr == A_SET);
        sel.clr_wr  = wr_req && (addr == A_CLR);
        sel.tgl_wr  = wr_req && (addr == A_TGL);
        sel.dir_wr  = wr_req && (addr == A_DIR);
        sel.rd_en   = rd_req;
        sel.rd_data = rd_req && (addr == A_DATA);
        sel.rd_in   = rd_req && (addr == A_IN);
        sel.rd_dir  = rd_req && (addr == A_DIR);
    end

endmodule

// File: rtl/gpio_out_latch.sv
// Output data latch with whole-word load and bitwise set, clear and invert.
// Assumes at most one of the write strobes is active per cycle (the decoder ensures it).
module gpio_out_latch #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             set_bits,
    input  logic             clr_bits,
    input  logic             inv_bits,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] q
);

    // Update the latch from whichever write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= wdata;
        end else if (set_bits) begin
            q <= q | wdata;
        end else if (clr_bits) begin
            q <= q & ~wdata;
        end else if (inv_bits) begin
            q <= q ^ wdata;
        end
    end

endmodule

// File: rtl/gpio_dir_reg.sv
// Per-pin direction register; bit 1 = output, bit 0 = input.
// Assumes a whole-word write; resets to all inputs.
module gpio_dir_reg #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] q
);

    // Load the direction word on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for the asynchronous pad inputs.
// Assumes STAGES >= 2; each pin is synchronized on its own (no word coherency).
module gpio_in_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);

    logic [NPINS-1:0] chain [STAGES];

    // First stage samples the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
// 32-pin GPIO port top: register decode, output latch, direction, input sync, pad drive.
// Assumes a single-cycle request port; read data is registered and held between reads.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    gpio_sel_t        sel;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] in_q;
    logic [NPINS-1:0] rd_mux;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid (reg_valid),
        .write (reg_write),
        .addr  (reg_addr),
        .sel   (sel)
    );

    gpio_out_latch #(.NPINS(NPINS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel.data_wr),
        .set_bits (sel.set_wr),
        .clr_bits (sel.clr_wr),
        .inv_bits (sel.tgl_wr),
        .wdata    (reg_wdata),
        .q        (latch_q)
    );

    gpio_dir_reg #(.NPINS(NPINS)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel.dir_wr),
        .wdata (reg_wdata),
        .q     (dir_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_q)
    );

    // Select the word a read returns; aliases and unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (sel.rd_data) begin
            rd_mux = latch_q;
        end else if (sel.rd_in) begin
            rd_mux = in_q;
        end else if (sel.rd_dir) begin
            rd_mux = dir_q;
        end
    end

    // Register read data on each read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (sel.rd_en) begin
            reg_rdata <= rd_mux;
        end
    end

    // Drive the pads straight from the latch and direction register.
    always_comb begin
        pin_out = latch_q;
        pin_oe  = dir_q;
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind; observes ports only.
// Assumes the default two-stage synchronizer for the input-latency property.
module gpio_port_chk #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  reg_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);

    logic [2:0] up_cnt;
    logic       wr_any;
    logic       rd_any;

    // Count edges since reset release, saturating, to bound $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_cnt <= '0;
        end else if (up_cnt != 3'd7) begin
            up_cnt <= up_cnt + 3'd1;
        end
    end

    assign wr_any = reg_valid && reg_write;
    assign rd_any = reg_valid && !reg_write;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0) && (pin_oe == '0) && (reg_rdata == '0)); // R1

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(8'h00)) |=> pin_out == $past(reg_wdata)); // R2

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(8'h04)) |=> pin_out == ($past(pin_out) | $past(reg_wdata))); // R3

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(8'h08)) |=> pin_out == ($past(pin_out) & ~$past(reg_wdata))); // R4

    AST_INV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(8'h0C)) |=> pin_out == ($past(pin_out) ^ $past(reg_wdata))); // R5

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && reg_addr == ADDR_W'(8'h14)) |=> pin_oe == $past(reg_wdata)); // R6

    AST_IN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 3'd4 && rd_any && reg_addr == ADDR_W'(8'h10)) |=> reg_rdata == $past(pin_in, 3)); // R7

    AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (reg_addr == ADDR_W'(8'h04) || reg_addr == ADDR_W'(8'h08)
                    || reg_addr == ADDR_W'(8'h0C))) |=> reg_rdata == '0); // R8

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> $stable(pin_out) && $stable(pin_oe)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(reg_rdata)); // R9

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_port.sv
// Bench for gpio_port: a vector table walked by one loop, then directed tests.
module tb_gpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hA5A5_0F0F, 32'h0, 4'd2},         // R2 load
        '{1'b0, 8'h00, 32'h0, 32'hA5A5_0F0F, 4'd2},         // R2 readback
        '{1'b1, 8'h04, 32'h0000_F0F0, 32'h0, 4'd3},         // R3 set
        '{1'b0, 8'h00, 32'h0, 32'hA5A5_FFFF, 4'd3},
        '{1'b1, 8'h08, 32'hA000_000F, 32'h0, 4'd4},         // R4 clear
        '{1'b0, 8'h00, 32'h0, 32'h05A5_FFF0, 4'd4},
        '{1'b1, 8'h0C, 32'hFFFF_0000, 32'h0, 4'd5},         // R5 invert
        '{1'b0, 8'h00, 32'h0, 32'hFA5A_FFF0, 4'd5},
        '{1'b0, 8'h04, 32'h0, 32'h0, 4'd8},                 // R8 aliases read zero
        '{1'b0, 8'h08, 32'h0, 32'h0, 4'd8},
        '{1'b0, 8'h0C, 32'h0, 32'h0, 4'd8},
        '{1'b1, 8'h14, 32'h1234_5678, 32'h0, 4'd6},         // R6 direction
        '{1'b0, 8'h14, 32'h0, 32'h1234_5678, 4'd6},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd8},         // R8 input reg write ignored
        '{1'b0, 8'h00, 32'h0, 32'hFA5A_FFF0, 4'd8},
        '{1'b0, 8'h14, 32'h0, 32'h1234_5678, 4'd8},
        '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0, 4'd8},         // R8 unmapped
        '{1'b1, 8'h01, 32'h0, 32'h0, 4'd8},                 // R8 misaligned
        '{1'b0, 8'h18, 32'h0, 32'h0, 4'd8},
        '{1'b0, 8'h01, 32'h0, 32'h0, 4'd8},
        '{1'b0, 8'h00, 32'h0, 32'hFA5A_FFF0, 4'd8},
        '{1'b1, 8'h04, 32'h0000_0000, 32'h0, 4'd3},         // R3 zero mask
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0, 4'd5},         // R5 full invert
        '{1'b0, 8'h00, 32'h0, 32'h05A5_000F, 4'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end

        // R2 and R6: pads follow latch and direction.
        check("R2 pin_out", pin_out, 32'h05A5_000F);
        check("R6 pin_oe", pin_oe, 32'h1234_5678);

        // R7: synchronizer latency with back-to-back reads of the input register.
        pin_in = 32'hAAAA_5555;
        repeat (4) @(negedge clk);
        pin_in = 32'h1357_9BDF;
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 8'h10;
        @(negedge clk);
        check("R7 read at change edge", reg_rdata, 32'hAAAA_5555);
        @(negedge clk);
        check("R7 read one edge later", reg_rdata, 32'hAAAA_5555);
        @(negedge clk);
        check("R7 read two edges later", reg_rdata, 32'h1357_9BDF);
        reg_valid = 1'b0;

        // R9: read data holds while no read is issued.
        pin_in = 32'h0;
        do_write(8'h00, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R9 rdata hold", reg_rdata, 32'h1357_9BDF);
        check("R9 pin_oe unchanged by data write", pin_oe, 32'h1234_5678);

        // R1: reset mid-run clears drive and direction.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run pin_out", pin_out, 32'h0);
        check("R1 mid-run pin_oe", pin_oe, 32'h0);
        check("R1 mid-run rdata", reg_rdata, 32'h0);
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule